// File: doc/BRIEF.md
# I2C Command Buffer Controller

This block sits between a byte-level I2C slave front end and a command execution engine. The front end presents each received address byte, each written data byte and each read request as a one-cycle strobe. The block answers address and write strobes with a same-cycle ACK decision and answers read strobes with a same-cycle data byte. Incoming bytes fill a command buffer whose first byte gives the total packet length. When the last byte arrives, the block pulses a start to the engine, exposes the stored packet on a read port, and collects the engine's result bytes until a done pulse.

Every response is framed as an output block. The first byte is the block length, the status or result bytes follow, and the block ends in a two-byte CRC. The block spends one cycle per covered byte computing that CRC before it becomes readable. It then returns the block byte by byte and wraps around to the start for repeated reads.

The controller has six named states. SLEEP is entered from any state on `sleep_req` and left to READY on `wake_req`. IDLE is entered from READY or RECV on `idle_req` and left on `wake_req`: it returns to RECV if a packet is partly stored and to READY otherwise. READY holds a readable block and goes to RECV on a count byte of at least 4, or to WRAP on a count byte below 4. RECV goes to BUSY when the last packet byte is stored. BUSY goes to WRAP on `exec_done`. WRAP goes back to READY after the CRC is complete. Reset enters READY with the power-up block loaded.

Top module: `i2c_cbuf_ctrl`

## Requirements
- R1: An address byte is ACKed only when its bits 7..1 equal `dev_addr` and the state is READY or RECV. Its bit 0 set means read and clear means write. A NACKed address ends the current session, so later write strobes get no ACK and later read strobes return 0xFF.
- R2: In READY, the first ACKed write byte becomes the count, which is the total packet length including itself. In RECV, bytes are ACKed and stored only while fewer than count bytes are held, and only inside a write session.
- R3: At most 84 bytes are stored. When the count exceeds 84, the 85th and later bytes are NACKed and the packet never completes.
- R4: A packet may be split over any number of write sessions. The buffer position carries over from one session to the next.
- R5: Storing the final byte moves the state to BUSY. `exec_start` is high for exactly the first BUSY cycle, `cmd_len` gives the count, and `cmd_rdata` returns the stored byte at `cmd_raddr`.
- R6: In BUSY, WRAP, IDLE and SLEEP, every address byte, read or write, is NACKed.
- R7: In RECV, a read address is ACKed and every read byte is 0xFF. The partial packet is kept.
- R8: After reset, and after waking from SLEEP, the block is 0x04, 0x11, CRC low byte, CRC high byte.
- R9: A count byte below 4 is a parse error. It produces the block 0x04, 0x03, CRC and does not start the engine.
- R10: `exec_done` with `exec_err` set produces the block 0x04, `exec_code`, CRC.
- R11: A successful `exec_done` yields a block of n+3 bytes: count n+3, n result bytes, then CRC. Here n is the number of `res_vld` bytes, including one given in the same cycle as `exec_done`. Bytes beyond 32 are dropped.
- R12: The CRC covers the count byte and the payload. It starts at 0, uses polynomial 0x8005, and takes each byte least significant bit first, shifting the register left. The low byte is sent first.
- R13: Each read byte returns the next byte of the block. After the last byte, the pointer wraps to byte 0.
- R14: After an n-byte block is framed, it becomes readable (read address ACKed) exactly n-2 cycles after the edge that enters WRAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address, compared with address byte bits 7..1 |
| sleep_req | input | 1 | Force SLEEP |
| idle_req | input | 1 | Enter IDLE from READY or RECV |
| wake_req | input | 1 | Leave SLEEP or IDLE |
| addr_vld | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte, bit 0 = read |
| addr_ack | output | 1 | ACK for the address byte |
| wr_vld | input | 1 | Written data byte strobe |
| wr_byte | input | 8 | Written data byte |
| wr_ack | output | 1 | ACK for the written byte |
| rd_req | input | 1 | Read byte strobe |
| rd_data | output | 8 | Byte returned for the read strobe |
| exec_start | output | 1 | Engine start pulse |
| cmd_len | output | 8 | Packet count byte |
| cmd_raddr | input | 7 | Engine read address into the packet |
| cmd_rdata | output | 8 | Stored packet byte |
| res_vld | input | 1 | Result byte strobe from the engine |
| res_byte | input | 8 | Result byte |
| exec_done | input | 1 | Engine completion pulse |
| exec_err | input | 1 | Completion carries an error |
| exec_code | input | 8 | Error code |

## Verification
Two events can land on the same clock edge. The engine's last result byte can arrive together with its done pulse, and a read address byte can arrive in that same cycle. The bench drives all three at once. It expects the result byte to appear in the framed block and the length to count it, and it expects the address to be NACKed because the state is still BUSY. A cycle-accurate queue model in the bench predicts the ACKs and read bytes on every clock, including the countdown of WRAP cycles before the read address is ACKed again.

// File: rtl/i2c_cbuf_pkg.sv
package i2c_cbuf_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP, ST_IDLE, ST_READY, ST_RECV, ST_BUSY, ST_WRAP
    } state_t;

    typedef enum logic [1:0] {SS_NONE, SS_WR, SS_RD} sess_t;

    localparam logic [7:0] PWR_STATUS = 8'h11;
    localparam logic [7:0] PARSE_ERR  = 8'h03;

    // One byte into the running CRC, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = d[i] ^ r[15];
            r  = {r[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
        return r;
    endfunction

    localparam logic [15:0] PWR_CRC = crc16_step(crc16_step(16'h0000, 8'h04), PWR_STATUS);
endpackage

// File: rtl/i2c_cbuf_cmdmem.sv
module i2c_cbuf_cmdmem #(
    parameter int DEPTH = 84,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/i2c_cbuf_payload.sv
module i2c_cbuf_payload #(
    parameter int         DEPTH = 32,
    parameter int         AW    = $clog2(DEPTH),
    parameter logic [7:0] RST0  = 8'h11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ent[g] <= (g == 0) ? RST0 : 8'h00;
            else if (we && waddr == AW'(g))     ent[g] <= wdata;
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/i2c_cbuf_ctrl.sv
module i2c_cbuf_ctrl
    import i2c_cbuf_pkg::*;
#(
    parameter int BUF_BYTES = 84,
    parameter int MAX_RES   = 32,
    parameter int MIN_CMD   = 4,
    localparam int CMD_AW   = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        dev_addr,
    input  logic              sleep_req,
    input  logic              idle_req,
    input  logic              wake_req,
    input  logic              addr_vld,
    input  logic [7:0]        addr_byte,
    output logic              addr_ack,
    input  logic              wr_vld,
    input  logic [7:0]        wr_byte,
    output logic              wr_ack,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              exec_start,
    output logic [7:0]        cmd_len,
    input  logic [CMD_AW-1:0] cmd_raddr,
    output logic [7:0]        cmd_rdata,
    input  logic              res_vld,
    input  logic [7:0]        res_byte,
    input  logic              exec_done,
    input  logic              exec_err,
    input  logic [7:0]        exec_code
);
    localparam int PTR_W  = CMD_AW + 1;
    localparam int BLK_W  = $clog2(MAX_RES + 4);
    localparam int RES_W  = $clog2(MAX_RES + 1);
    localparam int PAY_AW = $clog2(MAX_RES);

    state_t             st_q, st_d;
    sess_t              sess_q;
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [7:0]         cnt_q;
    logic [BLK_W-1:0]   len_q, rd_ptr_q, wrap_idx_q;
    logic [RES_W-1:0]   res_n_q, res_total;
    logic [15:0]        crc_q, acc_q;
    logic               start_q;

    logic               open_st, room, wr_take, rd_live;
    logic [7:0]         lim, pay_rd, out_byte, wrap_byte;
    logic [BLK_W-1:0]   pay_idx;
    logic               pw_en;
    logic [PAY_AW-1:0]  pw_addr;
    logic [7:0]         pw_data;

    // ---------------- handshake decisions ----------------
    always_comb begin
        open_st   = (st_q == ST_READY) || (st_q == ST_RECV);
        lim       = (cnt_q > 8'(BUF_BYTES)) ? 8'(BUF_BYTES) : cnt_q;
        room      = (st_q == ST_READY) || (8'(wr_ptr_q) < lim);
        addr_ack  = addr_vld && (addr_byte[7:1] == dev_addr) && open_st;
        wr_take   = wr_vld && (sess_q == SS_WR) && open_st && room && !sleep_req && !idle_req;
        wr_ack    = wr_take;
        rd_live   = rd_req && (sess_q == SS_RD) && (st_q == ST_READY);
        res_total = res_n_q + RES_W'(res_vld && (res_n_q < RES_W'(MAX_RES)));
        pay_idx   = ((st_q == ST_WRAP) ? wrap_idx_q : rd_ptr_q) - BLK_W'(1);
        if (rd_ptr_q == 0)                         out_byte = 8'(len_q);
        else if (rd_ptr_q == len_q - BLK_W'(2))    out_byte = crc_q[7:0];
        else if (rd_ptr_q == len_q - BLK_W'(1))    out_byte = crc_q[15:8];
        else                                       out_byte = pay_rd;
        wrap_byte = (wrap_idx_q == 0) ? 8'(len_q) : pay_rd;
        rd_data   = rd_live ? out_byte : 8'hFF;
    end

    // ---------------- payload write port ----------------
    always_comb begin
        pw_en   = 1'b0;
        pw_addr = '0;
        pw_data = 8'h00;
        if (!sleep_req) begin
            if (st_q == ST_SLEEP && wake_req) begin
                pw_en = 1'b1; pw_data = PWR_STATUS;
            end else if (st_q == ST_READY && wr_take && wr_byte < 8'(MIN_CMD)) begin
                pw_en = 1'b1; pw_data = PARSE_ERR;
            end else if (st_q == ST_BUSY && exec_done && exec_err) begin
                pw_en = 1'b1; pw_data = exec_code;
            end else if (st_q == ST_BUSY && res_vld && res_n_q < RES_W'(MAX_RES)) begin
                pw_en = 1'b1; pw_addr = PAY_AW'(res_n_q); pw_data = res_byte;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (sleep_req) st_d = ST_SLEEP;
        else begin
            unique case (st_q)
                ST_SLEEP: if (wake_req) st_d = ST_READY;
                ST_IDLE:  if (wake_req) st_d = (wr_ptr_q == 0) ? ST_READY : ST_RECV;
                ST_READY: if (idle_req) st_d = ST_IDLE;
                          else if (wr_take) st_d = (wr_byte < 8'(MIN_CMD)) ? ST_WRAP : ST_RECV;
                ST_RECV:  if (idle_req) st_d = ST_IDLE;
                          else if (wr_take && (8'(wr_ptr_q) + 8'd1 == cnt_q)) st_d = ST_BUSY;
                ST_BUSY:  if (exec_done) st_d = ST_WRAP;
                ST_WRAP:  if (wrap_idx_q == len_q - BLK_W'(3)) st_d = ST_READY;
                default:  st_d = ST_SLEEP;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sess_q <= SS_NONE;  wr_ptr_q <= '0;  cnt_q <= 8'h00;
            len_q <= BLK_W'(4); rd_ptr_q <= '0;  wrap_idx_q <= '0;
            res_n_q <= '0;      crc_q <= PWR_CRC; acc_q <= 16'h0000;
            start_q <= 1'b0;
        end else begin
            start_q <= (st_q == ST_RECV) && (st_d == ST_BUSY);
            if (addr_vld) sess_q <= addr_ack ? (addr_byte[0] ? SS_RD : SS_WR) : SS_NONE;
            if (rd_live) rd_ptr_q <= (rd_ptr_q == len_q - BLK_W'(1)) ? '0 : rd_ptr_q + BLK_W'(1);
            if (wr_take) begin
                if (st_q == ST_READY) begin
                    cnt_q <= wr_byte; wr_ptr_q <= PTR_W'(1);
                end else begin
                    wr_ptr_q <= wr_ptr_q + PTR_W'(1);
                end
            end
            if (st_q == ST_SLEEP && st_d == ST_READY) begin
                len_q <= BLK_W'(4); crc_q <= PWR_CRC; rd_ptr_q <= '0;
            end
            if (st_q == ST_RECV && st_d == ST_BUSY) begin
                wr_ptr_q <= '0; res_n_q <= '0;
            end
            if (st_q == ST_BUSY && res_vld && res_n_q < RES_W'(MAX_RES)) res_n_q <= res_n_q + RES_W'(1);
            if (st_q != ST_WRAP && st_d == ST_WRAP) begin
                wrap_idx_q <= '0; acc_q <= 16'h0000; wr_ptr_q <= '0;
                if (st_q == ST_READY || exec_err) len_q <= BLK_W'(4);
                else                              len_q <= BLK_W'(res_total) + BLK_W'(3);
            end
            if (st_q == ST_WRAP) begin
                acc_q      <= crc16_step(acc_q, wrap_byte);
                wrap_idx_q <= wrap_idx_q + BLK_W'(1);
                if (st_d == ST_READY) begin
                    crc_q <= crc16_step(acc_q, wrap_byte); rd_ptr_q <= '0;
                end
            end
            if (sleep_req) begin
                sess_q <= SS_NONE; wr_ptr_q <= '0;
            end
        end
    end

    assign exec_start = start_q;
    assign cmd_len    = cnt_q;

    i2c_cbuf_cmdmem #(.DEPTH(BUF_BYTES), .AW(CMD_AW)) u_cmdmem (
        .clk   (clk),
        .we    (wr_take),
        .waddr ((st_q == ST_READY) ? '0 : wr_ptr_q[CMD_AW-1:0]),
        .wdata (wr_byte),
        .raddr (cmd_raddr),
        .rdata (cmd_rdata)
    );

    i2c_cbuf_payload #(.DEPTH(MAX_RES), .AW(PAY_AW), .RST0(PWR_STATUS)) u_payload (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pw_en),
        .waddr (pw_addr),
        .wdata (pw_data),
        .raddr (pay_idx[PAY_AW-1:0]),
        .rdata (pay_rd)
    );

    // ---------------- assertions ----------------
    // R5
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> st_q == ST_BUSY);
    // R3
    buf_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_q <= PTR_W'(BUF_BYTES));
    // R3
    full_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_ptr_q >= PTR_W'(BUF_BYTES)) |-> !wr_ack);
    // R13
    rd_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY) |-> rd_ptr_q < len_q);
    // R11
    blk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q >= BLK_W'(4) && len_q <= BLK_W'(MAX_RES + 3));
    // R6
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && (st_q == ST_BUSY || st_q == ST_WRAP)) |-> !addr_ack);
    // R7
    partial_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && st_q == ST_RECV) |-> rd_data == 8'hFF);
    // R11
    result_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && exec_done && !exec_err) |-> res_total != 0);
endmodule

// File: tb/i2c_cbuf_ctrl_bench.sv
module i2c_cbuf_ctrl_bench;
    localparam int PER = 10;
    localparam logic [7:0] DEVW = 8'hC8;
    localparam logic [7:0] DEVR = 8'hC9;
    typedef byte unsigned bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 0, idle_req = 0, wake_req = 0;
    logic addr_vld = 0, wr_vld = 0, rd_req = 0, res_vld = 0, exec_done = 0, exec_err = 0;
    logic [7:0] addr_byte = 0, wr_byte = 0, res_byte = 0, exec_code = 0;
    logic [6:0] cmd_raddr = 0;
    logic addr_ack, wr_ack, exec_start;
    logic [7:0] rd_data, cmd_len, cmd_rdata;

    i2c_cbuf_ctrl u_i2c_cbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_addr(DEVW[7:1]), .sleep_req(sleep_req),
        .idle_req(idle_req), .wake_req(wake_req), .addr_vld(addr_vld),
        .addr_byte(addr_byte), .addr_ack(addr_ack), .wr_vld(wr_vld), .wr_byte(wr_byte),
        .wr_ack(wr_ack), .rd_req(rd_req), .rd_data(rd_data), .exec_start(exec_start),
        .cmd_len(cmd_len), .cmd_raddr(cmd_raddr), .cmd_rdata(cmd_rdata),
        .res_vld(res_vld), .res_byte(res_byte), .exec_done(exec_done),
        .exec_err(exec_err), .exec_code(exec_code));

    always #(PER/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    string tag = "R8";

    function automatic int crc_of(bq_t q);
        int c = 0;
        foreach (q[i])
            for (int b = 0; b < 8; b++)
                if ((((c >> 15) & 1) ^ ((q[i] >> b) & 1)) != 0) c = ((c << 1) ^ 'h8005) & 'hFFFF;
                else                                             c = (c << 1) & 'hFFFF;
        return c;
    endfunction

    function automatic bq_t seal(bq_t p);
        bq_t r;
        int c;
        r.push_back(8'(p.size() + 3));
        foreach (p[i]) r.push_back(p[i]);
        c = crc_of(r);
        r.push_back(8'(c & 'hFF));
        r.push_back(8'((c >> 8) & 'hFF));
        return r;
    endfunction

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", t, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    // states: 0 SLEEP 1 IDLE 2 READY 3 RECV 4 BUSY 5 WRAP ; sessions: 0 none 1 write 2 read
    int m_st, m_sess, m_cnt, m_rp, m_left;
    bit m_start;
    bq_t m_cmd, m_pkt, m_blk, m_new, m_res;
    bit e_aack, e_wack, e_live;

    function automatic void calc();
        bit open = (m_st == 2 || m_st == 3);
        int lim = (m_cnt > 84) ? 84 : m_cnt;
        e_aack = addr_vld && (addr_byte[7:1] == DEVW[7:1]) && open;
        e_wack = wr_vld && m_sess == 1 && open && !sleep_req && !idle_req &&
                 (m_st == 2 || m_cmd.size() < lim);
        e_live = rd_req && m_sess == 2 && m_st == 2;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 2; m_sess = 0; m_cnt = 0; m_rp = 0; m_left = 0; m_start = 0;
            m_cmd.delete(); m_blk = seal('{8'h11});
        end else begin
            calc();
            m_start = 0;
            if (addr_vld) m_sess = e_aack ? (addr_byte[0] ? 2 : 1) : 0;
            if (sleep_req) begin
                m_st = 0; m_sess = 0; m_cmd.delete();
            end else begin
                if (e_live) m_rp = (m_rp == m_blk.size() - 1) ? 0 : m_rp + 1;
                case (m_st)
                    0: if (wake_req) begin m_st = 2; m_blk = seal('{8'h11}); m_rp = 0; end
                    1: if (wake_req) m_st = (m_cmd.size() == 0) ? 2 : 3;
                    2: if (idle_req) m_st = 1;
                       else if (e_wack) begin
                           m_cnt = wr_byte;
                           if (wr_byte < 4) begin m_new = seal('{8'h03}); m_left = 2; m_st = 5; end
                           else begin m_cmd = '{wr_byte}; m_st = 3; end
                       end
                    3: if (idle_req) m_st = 1;
                       else if (e_wack) begin
                           m_cmd.push_back(wr_byte);
                           if (m_cmd.size() == m_cnt) begin
                               m_pkt = m_cmd; m_cmd.delete(); m_res.delete();
                               m_st = 4; m_start = 1;
                           end
                       end
                    4: begin
                        if (res_vld && m_res.size() < 32) m_res.push_back(res_byte);
                        if (exec_done) begin
                            m_new  = exec_err ? seal('{exec_code}) : seal(m_res);
                            m_left = m_new.size() - 2; m_st = 5;
                        end
                    end
                    5: begin
                        m_left--;
                        if (m_left == 0) begin m_blk = m_new; m_rp = 0; m_st = 2; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #(PER/4);
        if (rst_n && !finished) begin
            calc();
            chk({tag, " addr_ack"}, addr_ack, e_aack);
            chk({tag, " wr_ack"}, wr_ack, e_wack);
            chk({tag, " rd_data"}, rd_data, e_live ? int'(m_blk[m_rp]) : 'hFF);
            chk({tag, " exec_start"}, exec_start, m_start);
        end
    end

    // ---------------- stimulus ----------------
    task automatic clr();
        addr_vld = 0; wr_vld = 0; rd_req = 0; res_vld = 0; exec_done = 0;
        exec_err = 0; sleep_req = 0; idle_req = 0; wake_req = 0;
    endtask
    task automatic nop(int n);
        repeat (n) begin @(negedge clk); clr(); end
    endtask
    task automatic adr(logic [7:0] b);
        @(negedge clk); clr(); addr_vld = 1; addr_byte = b;
    endtask
    task automatic wr(logic [7:0] b);
        @(negedge clk); clr(); wr_vld = 1; wr_byte = b;
    endtask
    task automatic rdx(string t, int exp);
        @(negedge clk); clr(); rd_req = 1;
        #(PER/4 + 1);
        chk(t, rd_data, exp);
    endtask
    task automatic res(logic [7:0] b, bit done);
        @(negedge clk); clr(); res_vld = 1; res_byte = b; exec_done = done;
    endtask
    task automatic read_block(string t, bq_t q);
        adr(DEVR);
        foreach (q[i]) rdx(t, q[i]);
    endtask

    initial begin
        bq_t exp;
        int acks;
        nop(3);
        rst_n = 1;
        #(PER/4 + 1);
        chk("R8 reset exec_start", exec_start, 0);
        chk("R8 reset rd_data", rd_data, 'hFF);
        tag = "R8";
        exp = seal('{8'h11});
        read_block("R8 power-up block", exp);
        tag = "R13";
        rdx("R13 wrap to count", 8'h04);
        rdx("R13 wrap second", 8'h11);

        tag = "R1";
        adr(8'h51);
        rdx("R1 mismatched address read", 'hFF);
        adr(8'h50);
        wr(8'h06);
        #(PER/4 + 1);
        chk("R1 write after NACK", wr_ack, 0);

        tag = "R4";
        adr(DEVW); wr(8'h06); wr(8'hA1); wr(8'hA2);
        tag = "R7";
        adr(DEVR);
        rdx("R7 partial read", 'hFF);
        rdx("R7 partial read 2", 'hFF);
        tag = "R4";
        adr(DEVW); wr(8'hA3); wr(8'hA4); wr(8'hA5);
        #(PER/4 + 1);
        chk("R4 last split byte ack", wr_ack, 1);
        @(negedge clk); clr();
        #(PER/4 + 1);
        chk("R5 start pulse", exec_start, 1);
        chk("R5 cmd_len", cmd_len, 6);
        exp = '{8'h06, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
        for (int i = 0; i < 6; i++) begin
            cmd_raddr = 7'(i);
            #1;
            chk("R5 packet readback", cmd_rdata, exp[i]);
        end
        tag = "R2";
        wr(8'hA6);
        #(PER/4 + 1);
        chk("R2 byte past count", wr_ack, 0);
        tag = "R6";
        adr(DEVR); adr(DEVW);
        tag = "R11";
        res(8'h10, 0); res(8'h20, 0);
        res(8'h30, 1); addr_vld = 1; addr_byte = DEVR;   // coinciding events
        tag = "R14";
        adr(DEVR);                                        // WRAP, 4 cycles
        nop(2);
        adr(DEVR);
        #(PER/4 + 1);
        chk("R14 still framing", addr_ack, 0);
        adr(DEVR);
        #(PER/4 + 1);
        chk("R14 readable after n-2", addr_ack, 1);
        tag = "R12";
        exp = seal('{8'h10, 8'h20, 8'h30});
        chk("R12 crc of result block", {exp[5], exp[4]}, crc_of('{8'h06, 8'h10, 8'h20, 8'h30}));
        read_block("R11 result block", exp);

        tag = "R10";
        adr(DEVW); wr(8'h04); wr(8'hB1); wr(8'hB2); wr(8'hB3);
        nop(1); res(8'h55, 0);
        @(negedge clk); clr(); exec_done = 1; exec_err = 1; exec_code = 8'h0F;
        nop(4);
        read_block("R10 error block", seal('{8'h0F}));

        tag = "R9";
        adr(DEVW); wr(8'h02);
        nop(4);
        read_block("R9 parse error block", seal('{8'h03}));

        tag = "R3";
        adr(DEVW);
        acks = 0;
        for (int i = 0; i < 90; i++) begin
            wr(i == 0 ? 8'd100 : 8'(i));
            #(PER/4 + 1);
            acks += wr_ack;
        end
        chk("R3 ACKed bytes with count 100", acks, 84);

        tag = "R6";
        @(negedge clk); clr(); sleep_req = 1;
        adr(DEVR);
        #(PER/4 + 1);
        chk("R6 asleep NACK", addr_ack, 0);
        @(negedge clk); clr(); wake_req = 1;
        tag = "R8";
        read_block("R8 wake block", seal('{8'h11}));

        tag = "R14";
        adr(DEVW); wr(8'h05); wr(8'h01);
        @(negedge clk); clr(); idle_req = 1;
        adr(DEVW);
        #(PER/4 + 1);
        chk("R6 idle NACK", addr_ack, 0);
        @(negedge clk); clr(); wake_req = 1;
        adr(DEVW); wr(8'h02); wr(8'h03); wr(8'h04);
        nop(1);
        tag = "R11";
        for (int i = 0; i < 34; i++) res(8'(8'h40 + i), i == 33);
        nop(34);
        exp.delete();
        for (int i = 0; i < 32; i++) exp.push_back(8'(8'h40 + i));
        exp = seal(exp);
        chk("R11 capped length", exp[0], 35);
        read_block("R11 capped block", exp);
        rdx("R13 wrap after 35", 8'h23);

        nop(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule